// File: doc/BRIEF.md
# Byte-Lane Memory Interface with Unaligned Split

This block connects a CPU core to a 16-bit memory whose two byte lanes can be enabled separately. The core issues one request at a time: a read or a write, one byte or one 16-bit word, at any byte address. The block turns each request into one or two bus accesses. For each access it drives a word address, a read line, an odd-byte flag (byte address bit 0) and a low-lane strobe. The odd-byte flag and the strobe together say which lanes take part.

Memory is big-endian. The byte at the even address sits in the high lane, bits 15:8. Its odd neighbour sits in the low lane, bits 7:0. A word at an odd address spans two memory words. The block splits it into two accesses and puts the two bytes back in the right order, so the core always sees or supplies the most significant byte at the lower address.

The memory registers its read data: the word read by an access is on `bus_rdata` during the following cycle. The core learns the outcome through a `busy` level and a one-cycle `done` pulse.

Top module: `bytelane_mem_if`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy`, `done` and `bus_en` are all 0.
- R2: Each bus access drives one of three lane codes, written as (`bus_odd`, `bus_lo_strobe`). (0,1) enables both lanes. (0,0) enables only the high lane, bits 15:8, which holds the even byte. (1,1) enables only the low lane, bits 7:0, which holds the odd byte. The code (1,0) is never driven while `bus_en` is 1.
- R3: A byte read at address A takes one access to word A>>1 and uses the lane selected by A[0]. `rd_data` returns the byte in bits 7:0 with bits 15:8 set to zero. If the request is accepted at clock edge k, `done` is high in the cycle after edge k+2.
- R4: A word read at an even address A takes one access with both lanes. It returns byte A in `rd_data[15:8]` and byte A+1 in `rd_data[7:0]`, with `done` in the cycle after edge k+2.
- R5: A word read at an odd address A takes two accesses. The first goes to word A>>1 with the low lane only. The second goes to the next word with the high lane only. The result is {byte A, byte A+1}, with `done` in the cycle after edge k+3.
- R6: A byte write stores `req_wdata[7:0]` at address A and changes no other byte. It takes one access, with `done` in the cycle after edge k+1.
- R7: A word write at an even address takes a single access with both lanes. It stores `req_wdata[15:8]` at A and `req_wdata[7:0]` at A+1, with `done` in the cycle after edge k+1.
- R8: A word write at an odd address takes two accesses. It stores `req_wdata[15:8]` at A and `req_wdata[7:0]` at A+1, changes no other byte, and raises `done` in the cycle after edge k+2.
- R9: The word address of the second access wraps modulo the word address space. A word access at the last byte address reaches byte 0 as its second byte.
- R10: A request is accepted only when `busy` is 0. A `req_valid` raised while `busy` is 1 issues no bus access and changes no memory byte.
- R11: `done` lasts exactly one cycle and is never high together with `busy`. `busy` is 1 from the cycle after acceptance until the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 2*LANE_W | Write data; a byte write uses bits 7:0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 2*LANE_W | Read result, valid while done is high and held afterwards |
| bus_en | output | 1 | Bus access in this cycle |
| bus_read | output | 1 | 1 = read access, 0 = write access |
| bus_waddr | output | ADDR_W-1 | Word address |
| bus_odd | output | 1 | Byte address bit 0 of the access |
| bus_lo_strobe | output | 1 | Low-lane strobe, combined with bus_odd into the lane code |
| bus_wdata | output | 2*LANE_W | Write data on both lanes |
| bus_rdata | input | 2*LANE_W | Read word, valid in the cycle after the access |

## Verification
Each request's latency is measured as the number of rising edges from the acceptance edge to the first falling edge at which `done` is high. The expected value is 1 for aligned writes and byte writes, 2 for odd-address word writes and all single-access reads, and 3 for odd-address word reads. The bench drives inputs and samples outputs only on falling edges. It counts bus accesses per request with its own memory model. That model updates on the access edge and presents read data one cycle later, so `rd_data` is compared in the `done` cycle and the memory image right after it.

// File: rtl/bli_pkg.sv
`timescale 1ns/1ps
package bli_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FIRST   = 2'd1,
        ST_SECOND  = 2'd2,
        ST_CAPTURE = 2'd3
    } bli_state_e;

    typedef enum logic [1:0] {
        LN_BOTH = 2'd0,
        LN_HIGH = 2'd1,
        LN_LOW  = 2'd2
    } bli_lane_e;

    function automatic logic lane_odd(input bli_lane_e ln);
        return (ln == LN_LOW);
    endfunction

    function automatic logic lane_strobe(input bli_lane_e ln);
        return (ln != LN_HIGH);
    endfunction

endpackage

// File: rtl/bli_lane_plan.sv
`timescale 1ns/1ps
module bli_lane_plan
    import bli_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wide,
    input  logic                second,
    input  logic [2*LANE_W-1:0] wdata,
    output logic [ADDR_W-2:0]   word_addr,
    output logic                odd,
    output logic                strobe,
    output logic [2*LANE_W-1:0] lane_wdata,
    output logic                split
);
    localparam int WADDR_W = ADDR_W - 1;

    logic [WADDR_W-1:0] base;
    bli_lane_e          lane;
    logic [LANE_W-1:0]  msb_byte;
    logic [LANE_W-1:0]  lsb_byte;

    always_comb begin
        base       = addr[ADDR_W-1:1];
        split      = wide & addr[0];
        msb_byte   = wdata[2*LANE_W-1:LANE_W];
        lsb_byte   = wdata[LANE_W-1:0];
        word_addr  = second ? base + 1'b1 : base;
        lane       = LN_BOTH;
        lane_wdata = wdata;
        if (!wide) begin
            lane       = addr[0] ? LN_LOW : LN_HIGH;
            lane_wdata = {lsb_byte, lsb_byte};
        end else if (split) begin
            if (second) begin
                lane       = LN_HIGH;
                lane_wdata = {lsb_byte, lsb_byte};
            end else begin
                lane       = LN_LOW;
                lane_wdata = {msb_byte, msb_byte};
            end
        end
        odd    = lane_odd(lane);
        strobe = lane_strobe(lane);
    end

endmodule

// File: rtl/bli_merge.sv
`timescale 1ns/1ps
module bli_merge #(
    parameter int LANE_W = 8
) (
    input  logic                wide,
    input  logic                odd_addr,
    input  logic [LANE_W-1:0]   first_byte,
    input  logic [2*LANE_W-1:0] word_in,
    output logic [2*LANE_W-1:0] result
);
    logic [LANE_W-1:0] hi_lane;
    logic [LANE_W-1:0] lo_lane;

    always_comb begin
        hi_lane = word_in[2*LANE_W-1:LANE_W];
        lo_lane = word_in[LANE_W-1:0];
        if (!wide)
            result = {{LANE_W{1'b0}}, (odd_addr ? lo_lane : hi_lane)};
        else if (odd_addr)
            result = {first_byte, hi_lane};
        else
            result = word_in;
    end

endmodule

// File: rtl/bytelane_mem_if.sv
`timescale 1ns/1ps
module bytelane_mem_if
    import bli_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_wide,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    output logic                busy,
    output logic                done,
    output logic [2*LANE_W-1:0] rd_data,
    output logic                bus_en,
    output logic                bus_read,
    output logic [ADDR_W-2:0]   bus_waddr,
    output logic                bus_odd,
    output logic                bus_lo_strobe,
    output logic [2*LANE_W-1:0] bus_wdata,
    input  logic [2*LANE_W-1:0] bus_rdata
);
    localparam int WORD_W  = 2 * LANE_W;
    localparam int WADDR_W = ADDR_W - 1;

    typedef struct packed {
        bli_state_e          state;
        logic [ADDR_W-1:0]   addr;
        logic                wide;
        logic                write;
        logic [WORD_W-1:0]   wdata;
        logic                bus_en;
        logic                bus_read;
        logic [WADDR_W-1:0]  bus_waddr;
        logic                bus_odd;
        logic                bus_strobe;
        logic [WORD_W-1:0]   bus_wdata;
        logic [LANE_W-1:0]   hold;
        logic [WORD_W-1:0]   rdata;
        logic                done;
    } regs_t;

    regs_t r_q, r_d;

    logic                idle_q;
    logic [ADDR_W-1:0]   plan_addr;
    logic                plan_wide;
    logic [WORD_W-1:0]   plan_wdata;
    logic                plan_second;
    logic [WADDR_W-1:0]  plan_waddr;
    logic                plan_odd;
    logic                plan_strobe;
    logic [WORD_W-1:0]   plan_lane_wdata;
    logic                plan_split;
    logic [WORD_W-1:0]   merged;

    assign idle_q      = (r_q.state == ST_IDLE);
    assign plan_addr   = idle_q ? req_addr  : r_q.addr;
    assign plan_wide   = idle_q ? req_wide  : r_q.wide;
    assign plan_wdata  = idle_q ? req_wdata : r_q.wdata;
    assign plan_second = (r_q.state == ST_FIRST);

    bli_lane_plan #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_plan (
        .addr       (plan_addr),
        .wide       (plan_wide),
        .second     (plan_second),
        .wdata      (plan_wdata),
        .word_addr  (plan_waddr),
        .odd        (plan_odd),
        .strobe     (plan_strobe),
        .lane_wdata (plan_lane_wdata),
        .split      (plan_split)
    );

    bli_merge #(.LANE_W(LANE_W)) u_merge (
        .wide       (r_q.wide),
        .odd_addr   (r_q.addr[0]),
        .first_byte (r_q.hold),
        .word_in    (bus_rdata),
        .result     (merged)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.bus_en = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr       = req_addr;
                    r_d.wide       = req_wide;
                    r_d.write      = req_write;
                    r_d.wdata      = req_wdata;
                    r_d.bus_en     = 1'b1;
                    r_d.bus_read   = !req_write;
                    r_d.bus_waddr  = plan_waddr;
                    r_d.bus_odd    = plan_odd;
                    r_d.bus_strobe = plan_strobe;
                    r_d.bus_wdata  = plan_lane_wdata;
                    r_d.state      = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (plan_split) begin
                    r_d.bus_en     = 1'b1;
                    r_d.bus_waddr  = plan_waddr;
                    r_d.bus_odd    = plan_odd;
                    r_d.bus_strobe = plan_strobe;
                    r_d.bus_wdata  = plan_lane_wdata;
                    r_d.state      = ST_SECOND;
                end else if (r_q.write) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.state = ST_CAPTURE;
                end
            end
            ST_SECOND: begin
                if (r_q.write) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.hold  = bus_rdata[LANE_W-1:0];
                    r_d.state = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                r_d.rdata = merged;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy          = !idle_q;
    assign done          = r_q.done;
    assign rd_data       = r_q.rdata;
    assign bus_en        = r_q.bus_en;
    assign bus_read      = r_q.bus_read;
    assign bus_waddr     = r_q.bus_waddr;
    assign bus_odd       = r_q.bus_odd;
    assign bus_lo_strobe = r_q.bus_strobe;
    assign bus_wdata     = r_q.bus_wdata;

    // R2: reserved lane code never reaches the bus
    p_lane_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> !(bus_odd && !bus_lo_strobe));

    // R11: completion lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done and busy never overlap
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: an accepted request starts a bus access in the next cycle
    p_accept_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (bus_en && busy));

    // R5, R9: second half of a split goes to the next word (wrapping), high lane only
    p_split_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FIRST && plan_split) |=>
            (bus_en && !bus_odd && !bus_lo_strobe &&
             bus_waddr == WADDR_W'($past(bus_waddr) + 1'b1)));

    // R7: aligned word write is one access, then done
    p_aligned_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_write && req_wide && !req_addr[0]) |=>
            (bus_en && !bus_read && !bus_odd && bus_lo_strobe) ##1 (done && !bus_en));

    // R10: no access starts from the idle state without a request
    p_no_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> !bus_en);

endmodule

// File: tb/sim_bytelane_mem_if.sv
`timescale 1ns/1ps
module sim_bytelane_mem_if;
    localparam int AW = 8;
    localparam int LW = 8;
    localparam int NB = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [15:0]    req_wdata = '0;
    logic           busy, done, bus_en, bus_read, bus_odd, bus_lo_strobe;
    logic [15:0]    rd_data, bus_wdata;
    logic [15:0]    bus_rdata = '0;
    logic [AW-2:0]  bus_waddr;

    logic [7:0] mem [NB];
    logic [7:0] refm [NB];
    int n_chk = 0, n_fail = 0, acc_cnt = 0, bad_code = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bytelane_mem_if #(.ADDR_W(AW), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .bus_en(bus_en),
        .bus_read(bus_read), .bus_waddr(bus_waddr), .bus_odd(bus_odd),
        .bus_lo_strobe(bus_lo_strobe), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    // memory model: byte array, lanes decoded from (odd, strobe); read data one cycle later
    always @(posedge clk) begin
        if (rst_n && bus_en) begin
            automatic int w = int'(bus_waddr);
            acc_cnt++;
            bus_rdata <= {mem[2*w], mem[2*w+1]};
            if (bus_odd && !bus_lo_strobe) bad_code++;
            if (!bus_read) begin
                if (!bus_odd && bus_lo_strobe) begin
                    mem[2*w] = bus_wdata[15:8]; mem[2*w+1] = bus_wdata[7:0];
                end else if (!bus_odd) mem[2*w] = bus_wdata[15:8];
                else mem[2*w+1] = bus_wdata[7:0];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit mem_match();
        for (int i = 0; i < NB; i++) if (mem[i] !== refm[i]) return 0;
        return 1;
    endfunction

    task automatic do_op(input bit wr, input bit wide, input int a, input logic [15:0] wd,
                         input bit intrude, output logic [15:0] rd, output int lat,
                         output int acc, output bit busy_ok);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_wide = wide; req_addr = AW'(a); req_wdata = wd;
        acc_cnt = 0;
        @(posedge clk);
        @(negedge clk);
        if (intrude) begin
            req_write = 1; req_wide = 1; req_addr = '0; req_wdata = 16'hDEAD;
        end else req_valid = 0;
        busy_ok = (busy === 1'b1) && (done === 1'b0);
        lat = 0;
        do begin
            @(posedge clk); @(negedge clk);
            req_valid = 0;
            lat++;
            if (!done && busy !== 1'b1) busy_ok = 0;
        end while (!done && lat < 8);
        rd = rd_data;
        acc = acc_cnt;
        @(negedge clk);
        if (done !== 1'b0) busy_ok = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, exp;
        int lat, acc;
        bit bok;
        for (int i = 0; i < NB; i++) begin mem[i] = 8'(i * 7 + 3); refm[i] = mem[i]; end
        repeat (3) @(negedge clk);
        chk(busy === 0 && done === 0 && bus_en === 0, "R1", "reset outputs",
            {busy, done, bus_en}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy === 0 && done === 0 && bus_en === 0, "R1", "after release",
            {busy, done, bus_en}, 0);

        // R6: byte writes over every address
        for (int a = 0; a < NB; a++) begin
            automatic logic [7:0] p = 8'(a) ^ 8'h5A;
            do_op(1, 0, a, {8'hEE, p}, 0, rd, lat, acc, bok);
            refm[a] = p;
            chk(lat == 1 && acc == 1, "R6", "byte write latency/accesses", lat*16+acc, 17);
            chk(mem_match(), "R6", "byte write image", a, a);
            chk(bok, "R11", "busy/done framing", 0, 1);
        end

        // R3: byte reads over every address
        for (int a = 0; a < NB; a++) begin
            do_op(0, 0, a, 16'h0, 0, rd, lat, acc, bok);
            chk(rd === {8'h00, refm[a]}, "R3", "byte read data", rd, {8'h00, refm[a]});
            chk(lat == 2 && acc == 1, "R3", "byte read latency/accesses", lat*16+acc, 33);
        end

        // R4/R5/R9: word reads over every address
        for (int a = 0; a < NB; a++) begin
            exp = {refm[a], refm[(a+1) % NB]};
            do_op(0, 1, a, 16'h0, 0, rd, lat, acc, bok);
            if (a % 2 == 0) begin
                chk(rd === exp, "R4", "even word read", rd, exp);
                chk(lat == 2 && acc == 1, "R4", "even read latency/accesses", lat*16+acc, 33);
            end else begin
                chk(rd === exp, (a == NB-1) ? "R9" : "R5", "odd word read", rd, exp);
                chk(lat == 3 && acc == 2, "R5", "odd read latency/accesses", lat*16+acc, 50);
            end
            chk(bok, "R11", "busy/done framing", 0, 1);
        end

        // R7/R8/R9: word writes over every address, then read back
        for (int a = 0; a < NB; a++) begin
            automatic logic [15:0] q = 16'(a * 16'h0123 + 16'h8000);
            do_op(1, 1, a, q, 0, rd, lat, acc, bok);
            refm[a] = q[15:8]; refm[(a+1) % NB] = q[7:0];
            if (a % 2 == 0) begin
                chk(lat == 1 && acc == 1, "R7", "even write latency/accesses", lat*16+acc, 17);
                chk(mem_match(), "R7", "even write image", a, a);
            end else begin
                chk(lat == 2 && acc == 2, "R8", "odd write latency/accesses", lat*16+acc, 34);
                chk(mem_match(), (a == NB-1) ? "R9" : "R8", "odd write image", a, a);
            end
            do_op(0, 1, a, 16'h0, 0, rd, lat, acc, bok);
            chk(rd === q, "R8", "word readback", rd, q);
        end

        // R10: request raised while busy is ignored
        do_op(0, 1, 5, 16'h0, 1, rd, lat, acc, bok);
        exp = {refm[5], refm[6]};
        chk(rd === exp, "R10", "read during intrusion", rd, exp);
        chk(acc == 2, "R10", "access count with intrusion", acc, 2);
        chk(mem_match(), "R10", "memory untouched by ignored write", 0, 0);
        chk(busy === 0 && bus_en === 0, "R10", "idle after ignored request", {busy, bus_en}, 0);

        chk(bad_code == 0, "R2", "reserved lane code seen", bad_code, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule